// File: doc/BRIEF.md
# Memory Tag Check Unit

This unit sits in the load/store path of a processor pipeline. It checks one memory access at a time against a lock-and-key tagging scheme. Each access brings a 64-bit virtual address whose upper bits carry a 4-bit pointer tag. It also brings the current privilege level, whether the translation regime has one or two address ranges, a per-range enable that lets the top byte be ignored, a per-range enable for tag values that are always treated as matching, and the fault-mode fields. The unit strips the tag to form the clean address that goes on to translation. It decides whether the access needs a check and, when it does, asks an external tag store for the allocation tag of the addressed granule.

When the two tags differ, the fault mode selected for the current privilege level sets the outcome. The access may go on as if nothing happened. It may be returned as a synchronous abort that carries the tag-check fault status code and the full tagged address. Or it may complete normally while a sticky per-range bit is set in an asynchronous fault-status register, with one register for level 0 and another for all higher levels. Software clears those bits by a write-one-to-clear strobe.

Top module: `tag_check_unit`

## Requirements
- R1: The pointer tag is address bits [59:56] and the range-select bit is address bit 55. In a single-range regime (`req_two_range`=0) a checked access yields a clean address equal to bits [55:0] with bits [63:56] forced to zero.
- R2: In a two-range regime a checked access yields bits [55:0] with bits [63:56] all copies of bit 55.
- R3: The top-byte-ignore enable is `req_tbi[sel]` in a two-range regime and `req_tbi[0]` in a single-range regime. When it is clear, the access is unchecked, no lookup is issued, and `res_addr` equals the unmodified input address.
- R4: An access is unchecked, and returns the stripped address with no lookup, in three cases: two-range with select 0, tag 0x0 and `req_tcma[0]` set; two-range with select 1, tag 0xF and `req_tcma[1]` set; single-range with tag 0x0 and `req_tcma[0]` set. Other combinations, for example select 0 and tag 0 with only `req_tcma[1]` set, are checked.
- R5: A lookup answered with `tag_rsp_none`=1 completes without abort, without a diagnostic flag and without a status update, whatever the returned tag.
- R6: The fault mode is `req_tcf[1:0]` (control bits [39:38]) when `req_el`=0 and `req_tcf[3:2]` (control bits [41:40]) otherwise.
- R7: On a mismatch, mode 0 has no effect. Mode 3 also leaves the access and the status untouched but raises `res_reserved` with the result.
- R8: On a mismatch in mode 1 the result has `res_abort`=1, `res_fsc`=6'h11 and `res_fault_addr` equal to the full tagged input address. A result without an abort shows `res_fsc`=0 and `res_fault_addr`=0.
- R9: On a mismatch in mode 2 the bit indexed by the select bit is set in `fsr_el0` when `req_el`=0 and in `fsr_elx` otherwise. Bits stay set across accesses until a `clr_valid` pulse with `clr_mask` clears them in the register chosen by `clr_el0`. A set and a clear of the same bit in the same cycle leave it set.
- R10: Accesses use a valid/ready handshake. `req_ready` is high only when the unit is idle, so at most one lookup is outstanding, and a result is held unchanged until `res_ready` accepts it.
- R11: An unchecked access shows `res_valid` in the cycle after it is accepted. A checked access holds `tag_req_valid` with the clean address until `tag_rsp_valid` arrives, whatever the latency, and its result shows in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | 64 | Tagged virtual address |
| req_el | input | 2 | Privilege level of the access |
| req_two_range | input | 1 | Regime has two address ranges |
| req_tbi | input | 2 | Top-byte-ignore enable per range |
| req_tcma | input | 2 | Match-ignore enable per range |
| req_tcf | input | 4 | Fault modes: [1:0] level 0, [3:2] other levels |
| tag_req_valid | output | 1 | Tag lookup outstanding |
| tag_req_addr | output | 64 | Clean address for the lookup |
| tag_rsp_valid | input | 1 | Lookup response strobe |
| tag_rsp_tag | input | 4 | Stored allocation tag |
| tag_rsp_none | input | 1 | Addressed memory has no tag storage |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_addr | output | 64 | Clean (or pass-through) address |
| res_abort | output | 1 | Synchronous tag-check abort |
| res_fsc | output | 6 | Fault status code |
| res_fault_addr | output | 64 | Faulting tagged address |
| res_reserved | output | 1 | Mismatch seen under reserved fault mode |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_el0 | input | 1 | Clear targets level-0 register |
| clr_mask | input | 2 | Bits to clear |
| fsr_el0 | output | 2 | Async fault status, level 0 |
| fsr_elx | output | 2 | Async fault status, higher levels |

## Verification
The hardest case to reach is a mismatch whose outcome depends on picking the right fault-mode field, because a unit that reads the wrong field can still look correct when both fields hold the same value. Every access in the bench therefore loads the unused field with the bitwise complement of the intended mode, so a wrong selection turns an abort into a status update or the other way round. Sticky accumulation is reached by mode-2 mismatches at level 0 and at a higher level that differ in select bit, followed by a partial clear. Response latency is varied from zero to several cycles so that the stall path and the hold of the result are both exercised.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int ADDR_W   = 64;
  localparam int TAG_W    = 4;
  localparam int TAG_LSB  = 56;
  localparam int SEL_BIT  = 55;
  localparam int NRANGE   = 2;
  localparam int FSC_W    = 6;
  localparam logic [FSC_W-1:0] FSC_TAG = 6'h11;
  localparam int EXT_W    = ADDR_W - SEL_BIT - 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_DONE   = 2'd2
  } tcu_state_e;

  typedef enum logic [1:0] {
    FM_IGNORE = 2'd0,
    FM_SYNC   = 2'd1,
    FM_ASYNC  = 2'd2,
    FM_RSVD   = 2'd3
  } tcu_mode_e;
endpackage

// File: rtl/tcu_addr_decode.sv
module tcu_addr_decode
  import tcu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              two_range,
  input  logic [NRANGE-1:0] tbi,
  input  logic [NRANGE-1:0] tcma,
  output logic [TAG_W-1:0]  ptr_tag,
  output logic              sel,
  output logic [ADDR_W-1:0] out_addr,
  output logic              need_check
);
  logic [ADDR_W-1:0] stripped;
  logic              tbi_on;
  logic              match_ign;

  always_comb begin
    sel      = addr[SEL_BIT];
    ptr_tag  = addr[TAG_LSB +: TAG_W];
    stripped = two_range ? {{EXT_W{addr[SEL_BIT]}}, addr[SEL_BIT:0]}
                         : {{EXT_W{1'b0}}, addr[SEL_BIT:0]};
    tbi_on   = two_range ? tbi[sel] : tbi[0];
    if (two_range) begin
      match_ign = (!sel && (ptr_tag == '0) && tcma[0]) ||
                  ( sel && (ptr_tag == '1) && tcma[1]);
    end else begin
      match_ign = (ptr_tag == '0) && tcma[0];
    end
    need_check = tbi_on && !match_ign;
    out_addr   = tbi_on ? stripped : addr;
  end
endmodule

// File: rtl/tcu_fault_sel.sv
module tcu_fault_sel
  import tcu_pkg::*;
(
  input  logic [1:0]       req_el,
  input  logic [3:0]       req_tcf,
  output tcu_mode_e        mode_sel,
  input  tcu_mode_e        mode_q,
  input  logic             rsp_fire,
  input  logic             rsp_none,
  input  logic [TAG_W-1:0] mem_tag,
  input  logic [TAG_W-1:0] ptr_tag,
  output logic             do_abort,
  output logic             do_async,
  output logic             do_rsvd
);
  logic mismatch;

  always_comb begin
    mode_sel = tcu_mode_e'((req_el == 2'd0) ? req_tcf[1:0] : req_tcf[3:2]);
    mismatch = rsp_fire && !rsp_none && (mem_tag != ptr_tag);
    do_abort = mismatch && (mode_q == FM_SYNC);
    do_async = mismatch && (mode_q == FM_ASYNC);
    do_rsvd  = mismatch && (mode_q == FM_RSVD);
  end
endmodule

// File: rtl/tcu_sticky_status.sv
module tcu_sticky_status
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              set_el0,
  input  logic              set_sel,
  input  logic              clr_valid,
  input  logic              clr_el0,
  input  logic [NRANGE-1:0] clr_mask,
  output logic [NRANGE-1:0] fsr_el0,
  output logic [NRANGE-1:0] fsr_elx
);
  logic [NRANGE-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              hit_set;
    logic              hit_clr;
    logic [NRANGE-1:0] bank_d;

    always_comb begin
      hit_set = set_en && (set_el0 == (b == 0));
      hit_clr = clr_valid && (clr_el0 == (b == 0));
      bank_d  = bank_q[b];
      if (hit_clr) bank_d = bank_d & ~clr_mask;
      if (hit_set) bank_d = bank_d | (NRANGE'(1) << set_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[b] <= '0;
      else        bank_q[b] <= bank_d;
    end

    // R9: bits never drop without a clear strobe
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_valid |=> ((bank_q[b] & $past(bank_q[b])) == $past(bank_q[b])));
  end

  assign fsr_el0 = bank_q[0];
  assign fsr_elx = bank_q[1];
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_el,
  input  logic              req_two_range,
  input  logic [1:0]        req_tbi,
  input  logic [1:0]        req_tcma,
  input  logic [3:0]        req_tcf,
  output logic              tag_req_valid,
  output logic [ADDR_W-1:0] tag_req_addr,
  input  logic              tag_rsp_valid,
  input  logic [3:0]        tag_rsp_tag,
  input  logic              tag_rsp_none,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_abort,
  output logic [5:0]        res_fsc,
  output logic [ADDR_W-1:0] res_fault_addr,
  output logic              res_reserved,
  input  logic              clr_valid,
  input  logic              clr_el0,
  input  logic [1:0]        clr_mask,
  output logic [1:0]        fsr_el0,
  output logic [1:0]        fsr_elx
);
  tcu_state_e        state_q, state_d;
  logic [ADDR_W-1:0] orig_q, clean_q;
  logic [TAG_W-1:0]  tag_q;
  logic              sel_q, el0_q;
  tcu_mode_e         mode_q;
  logic              abort_q, abort_d, rsvd_q, rsvd_d;

  logic              accept, rsp_fire, ld_req, ld_res;
  logic [TAG_W-1:0]  dec_tag;
  logic              dec_sel, dec_chk;
  logic [ADDR_W-1:0] dec_addr;
  tcu_mode_e         mode_sel;
  logic              do_abort, do_async, do_rsvd;

  tcu_addr_decode u_decode (
    .addr(req_addr), .two_range(req_two_range), .tbi(req_tbi), .tcma(req_tcma),
    .ptr_tag(dec_tag), .sel(dec_sel), .out_addr(dec_addr), .need_check(dec_chk)
  );

  tcu_fault_sel u_fault (
    .req_el(req_el), .req_tcf(req_tcf), .mode_sel(mode_sel),
    .mode_q(mode_q), .rsp_fire(rsp_fire), .rsp_none(tag_rsp_none),
    .mem_tag(tag_rsp_tag), .ptr_tag(tag_q),
    .do_abort(do_abort), .do_async(do_async), .do_rsvd(do_rsvd)
  );

  tcu_sticky_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_en(do_async), .set_el0(el0_q), .set_sel(sel_q),
    .clr_valid(clr_valid), .clr_el0(clr_el0), .clr_mask(clr_mask),
    .fsr_el0(fsr_el0), .fsr_elx(fsr_elx)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    abort_d  = abort_q;
    rsvd_d   = rsvd_q;
    accept   = 1'b0;
    rsp_fire = 1'b0;
    ld_res   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          ld_res  = 1'b1;
          abort_d = 1'b0;
          rsvd_d  = 1'b0;
          state_d = dec_chk ? ST_LOOKUP : ST_DONE;
        end
      end
      ST_LOOKUP: begin
        if (tag_rsp_valid) begin
          rsp_fire = 1'b1;
          ld_res   = 1'b1;
          abort_d  = do_abort;
          rsvd_d   = do_rsvd;
          state_d  = ST_DONE;
        end
      end
      ST_DONE: begin
        if (res_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    ld_req = accept;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      orig_q  <= '0;
      clean_q <= '0;
      tag_q   <= '0;
      sel_q   <= 1'b0;
      el0_q   <= 1'b0;
      mode_q  <= FM_IGNORE;
      abort_q <= 1'b0;
      rsvd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        orig_q  <= req_addr;
        clean_q <= dec_addr;
        tag_q   <= dec_tag;
        sel_q   <= dec_sel;
        el0_q   <= (req_el == 2'd0);
        mode_q  <= mode_sel;
      end
      if (ld_res) begin
        abort_q <= abort_d;
        rsvd_q  <= rsvd_d;
      end
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign tag_req_valid  = (state_q == ST_LOOKUP);
  assign tag_req_addr   = clean_q;
  assign res_valid      = (state_q == ST_DONE);
  assign res_addr       = clean_q;
  assign res_abort      = abort_q;
  assign res_fsc        = abort_q ? FSC_TAG : '0;
  assign res_fault_addr = abort_q ? orig_q : '0;
  assign res_reserved   = rsvd_q;

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_abort)
                                && $stable(res_reserved));

  assert_one_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req_valid |-> !req_ready && !res_valid);

  assert_lookup_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tag_req_valid && !tag_rsp_valid |=> tag_req_valid && $stable(tag_req_addr));

  assert_unchecked_fast_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dec_chk |=> res_valid);

  assert_abort_after_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) && res_abort |-> $past(tag_rsp_valid));
endmodule

// File: tb/tag_check_unit_bench.sv
`timescale 1ns/1ps
module tag_check_unit_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        req_valid, req_ready, req_two_range;
  logic [63:0] req_addr;
  logic [1:0]  req_el, req_tbi, req_tcma;
  logic [3:0]  req_tcf;
  logic        tag_req_valid, tag_rsp_valid, tag_rsp_none;
  logic [63:0] tag_req_addr;
  logic [3:0]  tag_rsp_tag;
  logic        res_valid, res_ready, res_abort, res_reserved;
  logic [63:0] res_addr, res_fault_addr;
  logic [5:0]  res_fsc;
  logic        clr_valid, clr_el0;
  logic [1:0]  clr_mask, fsr_el0, fsr_elx;

  tag_check_unit u_tag_check_unit (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic eq(input string rq, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, rq, act, exp);
  endtask

  // captured results of the last access
  logic        a_lookup, a_fast, a_abort, a_rsvd;
  logic [63:0] a_addr, a_faddr, a_lkaddr;
  logic [5:0]  a_fsc;

  task automatic access(input logic [63:0] a, input logic [1:0] el, input logic two,
                        input logic [1:0] tbi, input logic [1:0] tcma, input logic [1:0] mode,
                        input logic [3:0] mtag, input logic none, input int lat);
    int cyc;
    @(negedge clk);
    req_addr = a; req_el = el; req_two_range = two; req_tbi = tbi; req_tcma = tcma;
    // the unused field holds the complement so a wrong selection shows up
    req_tcf = (el == 2'd0) ? {~mode, mode} : {mode, ~mode};
    eq("R10 ready when idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    a_lookup = 1'b0; a_fast = res_valid; cyc = 0;
    while (!res_valid && cyc < 100) begin
      if (tag_req_valid) begin
        a_lookup = 1'b1;
        a_lkaddr = tag_req_addr;
        eq("R10 busy during lookup", {63'd0, req_ready}, 64'd0);
        repeat (lat) @(negedge clk);
        eq("R11 lookup held", {63'd0, tag_req_valid}, 64'd1);
        tag_rsp_valid = 1'b1; tag_rsp_tag = mtag; tag_rsp_none = none;
        @(negedge clk);
        tag_rsp_valid = 1'b0; tag_rsp_none = 1'b0;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    a_addr = res_addr; a_abort = res_abort; a_fsc = res_fsc;
    a_faddr = res_fault_addr; a_rsvd = res_reserved;
    @(negedge clk);
    eq("R10 result held", res_addr, a_addr);
    eq("R10 valid held", {63'd0, res_valid}, 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    eq("R10 released after accept", {63'd0, res_valid}, 64'd0);
  endtask

  function automatic logic [63:0] zx(input logic [63:0] a);
    return {8'h00, a[55:0]};
  endfunction
  function automatic logic [63:0] sx(input logic [63:0] a);
    return {{8{a[55]}}, a[55:0]};
  endfunction

  task automatic t_reset();
    eq("R10 reset ready", {63'd0, req_ready}, 64'd1);
    eq("R10 reset no result", {63'd0, res_valid}, 64'd0);
    eq("R11 reset no lookup", {63'd0, tag_req_valid}, 64'd0);
    eq("R9 reset status", {60'd0, fsr_el0, fsr_elx}, 64'd0);
  endtask

  task automatic t_single_range();
    logic [63:0] a = 64'hF5A0_1234_5678_9ABC;
    access(a, 2'd1, 1'b0, 2'b01, 2'b00, 2'd1, 4'h5, 1'b0, 1);
    eq("R1 lookup issued", {63'd0, a_lookup}, 64'd1);
    eq("R1 lookup addr", a_lkaddr, zx(a));
    eq("R1 clean zero-extended", a_addr, zx(a));
    eq("R1 tag match no abort", {63'd0, a_abort}, 64'd0);
    eq("R8 no abort fsc zero", {58'd0, a_fsc}, 64'd0);
    eq("R8 no abort faddr zero", a_faddr, 64'd0);
  endtask

  task automatic t_two_range();
    logic [63:0] a1 = 64'h0A80_0000_DEAD_BEEF;
    logic [63:0] a0 = 64'h0300_1111_2222_3333;
    access(a1, 2'd0, 1'b1, 2'b11, 2'b00, 2'd1, 4'hA, 1'b0, 0);
    eq("R2 sign-extended high range", a_addr, sx(a1));
    eq("R2 high range upper byte", {56'd0, a_addr[63:56]}, 64'hFF);
    access(a0, 2'd0, 1'b1, 2'b11, 2'b00, 2'd1, 4'h3, 1'b0, 2);
    eq("R2 low range upper byte zero", a_addr, sx(a0));
    eq("R2 match no abort", {63'd0, a_abort}, 64'd0);
  endtask

  task automatic t_tbi_off();
    logic [63:0] a = 64'h7B80_0000_0000_1000;
    access(a, 2'd1, 1'b1, 2'b01, 2'b00, 2'd1, 4'h0, 1'b0, 0);
    eq("R3 no lookup with tbi clear", {63'd0, a_lookup}, 64'd0);
    eq("R3 address unchanged", a_addr, a);
    eq("R11 unchecked in one cycle", {63'd0, a_fast}, 64'd1);
    access(64'h7B00_0000_0000_1000, 2'd1, 1'b0, 2'b10, 2'b00, 2'd1, 4'h0, 1'b0, 0);
    eq("R3 single range tbi[0] clear", a_addr, 64'h7B00_0000_0000_1000);
  endtask

  task automatic t_match_ignore();
    logic [63:0] a;
    a = 64'h1000_0000_0000_4000;  // tag 0, select 0
    access(a, 2'd1, 1'b1, 2'b11, 2'b01, 2'd1, 4'h7, 1'b0, 0);
    eq("R4 sel0 tag0 unchecked", {63'd0, a_lookup}, 64'd0);
    eq("R4 sel0 stripped", a_addr, sx(a));
    a = 64'h2F80_0000_0000_4000;  // tag F, select 1
    access(a, 2'd1, 1'b1, 2'b11, 2'b10, 2'd1, 4'h7, 1'b0, 0);
    eq("R4 sel1 tagF unchecked", {63'd0, a_lookup}, 64'd0);
    eq("R4 sel1 stripped", a_addr, sx(a));
    a = 64'h1000_0000_0000_4000;
    access(a, 2'd1, 1'b1, 2'b11, 2'b10, 2'd1, 4'h0, 1'b0, 0);
    eq("R4 wrong range bit still checked", {63'd0, a_lookup}, 64'd1);
    a = 64'h3000_0000_0000_8000;
    access(a, 2'd1, 1'b0, 2'b01, 2'b01, 2'd1, 4'h7, 1'b0, 0);
    eq("R4 single range tag0 unchecked", {63'd0, a_lookup}, 64'd0);
    eq("R4 single range stripped", a_addr, zx(a));
  endtask

  task automatic t_no_tag();
    access(64'h0500_0000_0000_0040, 2'd1, 1'b0, 2'b01, 2'b00, 2'd1, 4'h9, 1'b1, 2);
    eq("R5 no tag storage no abort", {63'd0, a_abort}, 64'd0);
    eq("R5 no diagnostic", {63'd0, a_rsvd}, 64'd0);
    access(64'h0500_0000_0000_0040, 2'd1, 1'b0, 2'b01, 2'b00, 2'd2, 4'h9, 1'b1, 0);
    eq("R5 no status update", {60'd0, fsr_el0, fsr_elx}, 64'd0);
  endtask

  task automatic t_sync_abort();
    logic [63:0] a = 64'h0C80_0000_0000_2000;
    access(a, 2'd1, 1'b1, 2'b11, 2'b00, 2'd1, 4'h4, 1'b0, 3);
    eq("R8 abort raised", {63'd0, a_abort}, 64'd1);
    eq("R8 fault status code", {58'd0, a_fsc}, 64'h11);
    eq("R8 tagged fault address", a_faddr, a);
    eq("R6 upper-level field used", {60'd0, fsr_el0, fsr_elx}, 64'd0);
    access(a, 2'd0, 1'b1, 2'b11, 2'b00, 2'd1, 4'h4, 1'b0, 0);
    eq("R6 level-0 field gives abort", {63'd0, a_abort}, 64'd1);
    eq("R6 level-0 no status", {60'd0, fsr_el0, fsr_elx}, 64'd0);
  endtask

  task automatic t_async();
    access(64'h0680_0000_0000_0100, 2'd0, 1'b1, 2'b11, 2'b00, 2'd2, 4'h1, 1'b0, 1);
    eq("R9 async no abort", {63'd0, a_abort}, 64'd0);
    eq("R9 level-0 sel1 bit", {62'd0, fsr_el0}, 64'd2);
    eq("R9 other register untouched", {62'd0, fsr_elx}, 64'd0);
    access(64'h0600_0000_0000_0100, 2'd2, 1'b1, 2'b11, 2'b00, 2'd2, 4'h1, 1'b0, 0);
    eq("R9 upper-level sel0 bit", {62'd0, fsr_elx}, 64'd1);
    access(64'h0600_0000_0000_0100, 2'd0, 1'b1, 2'b11, 2'b00, 2'd2, 4'h1, 1'b0, 0);
    eq("R9 level-0 accumulates", {62'd0, fsr_el0}, 64'd3);
    @(negedge clk);
    clr_valid = 1'b1; clr_el0 = 1'b1; clr_mask = 2'b10;
    @(negedge clk);
    clr_valid = 1'b0;
    eq("R9 partial clear level 0", {62'd0, fsr_el0}, 64'd1);
    eq("R9 clear leaves other register", {62'd0, fsr_elx}, 64'd1);
    @(negedge clk);
    clr_valid = 1'b1; clr_el0 = 1'b0; clr_mask = 2'b11;
    @(negedge clk);
    clr_valid = 1'b0;
    eq("R9 clear upper register", {62'd0, fsr_elx}, 64'd0);
  endtask

  task automatic t_ignore_reserved();
    access(64'h0900_0000_0000_0200, 2'd1, 1'b0, 2'b01, 2'b00, 2'd0, 4'h2, 1'b0, 1);
    eq("R7 mode 0 no abort", {63'd0, a_abort}, 64'd0);
    eq("R7 mode 0 no flag", {63'd0, a_rsvd}, 64'd0);
    eq("R7 mode 0 no status", {62'd0, fsr_elx}, 64'd0);
    access(64'h0900_0000_0000_0200, 2'd0, 1'b0, 2'b01, 2'b00, 2'd3, 4'h2, 1'b0, 0);
    eq("R7 mode 3 no abort", {63'd0, a_abort}, 64'd0);
    eq("R7 mode 3 diagnostic", {63'd0, a_rsvd}, 64'd1);
    eq("R7 mode 3 no status", {62'd0, fsr_el0}, 64'd1);
    eq("R7 mode 3 clean addr", a_addr, 64'h0000_0000_0000_0200);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_el = '0; req_two_range = 1'b0;
    req_tbi = '0; req_tcma = '0; req_tcf = '0; tag_rsp_valid = 1'b0; tag_rsp_tag = '0;
    tag_rsp_none = 1'b0; res_ready = 1'b0; clr_valid = 1'b0; clr_el0 = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_range();
    t_two_range();
    t_tbi_off();
    t_match_ignore();
    t_no_tag();
    t_sync_abort();
    t_async();
    t_ignore_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule